// File: doc/BRIEF.md
# Synchronous ROM Command Controller

This block is the control front end of a single-bank synchronous read-only memory. On every rising clock edge it samples chip select, the row and column strobes, the mode strobe, clock enable and the address bus. It decodes mode writes, row activation, reads and burst termination. It holds the operating mode (CAS latency, burst order, burst length) and the open row address. A one-cycle read request goes to a separate burst pipeline, carrying the column and the width select sampled with the read.

Clock enable is registered and gates an internal clock. A low sample while a burst is in flight freezes the read (Clock Suspend). A low sample while idle enters Power Down, and mode and row are kept. Nothing needs precharge, refresh or an initialization sequence: the mode is usable straight out of reset. After a mode write, commands are locked out for a fixed number of internal cycles.

Top module: `srom_cmd_ctrl`

## Requirements
- R1: After reset the mode is CAS latency 5, sequential order (`burst_il_o`=0) and burst length 4. The state is idle (0), the internal clock is enabled, the row is 0 and no pulse output is high.
- R2: Commands are decoded only with `cs_ni` low. Mode write = ras, cas and mr all low. Row activate = ras low, cas high. Read = ras high, cas low, mr high. Stop = ras high, cas high, mr low. A mode write sets the fields from `addr_i`: bits 5..3 set the latency (100=4, 101=5), bit 2 sets the order (1=interleave) and bits 1..0 set the length (01=4, 10=8). The new values show in the next cycle.
- R3: A reserved latency or length code leaves that field unchanged. `mrs_err_o` is then high for exactly one cycle. The order bit is still written.
- R4: For the 3 internal cycles after an accepted mode write, every command is ignored. A command in the 4th cycle is accepted.
- R5: A row activate latches `addr_i[12:0]` onto `row_o`. It holds until the next row activate.
- R6: A read raises `rd_req_o` for one cycle after the edge that sampled it. It also loads `rd_wide_o` from `wide_i`. `rd_col_o` is `addr_i[7:0]` when `wide_i`=0 (x16), or `addr_i[6:0]` zero-extended when `wide_i`=1 (x32).
- R7: After a read sampled at an active edge, `state_o` is 1 (read) for CL+BL-1 active cycles and then returns to 0. A new read or row activate may be issued during the burst.
- R8: A stop during a burst pulses `rd_stop_o` for one cycle and limits the remaining window to CL-1 cycles. A stop while idle is ignored.
- R9: `iclk_en_o` equals `cke_i` from the previous edge. At an edge where it is low, every other input is ignored and all state except `state_o` is held.
- R10: A low `cke_i` while idle gives state 3 (power down). Commands are ignored there. A high sample returns to state 0 with mode and row intact.
- R11: A low `cke_i` during the read window, including the read's own cycle, gives state 2 (suspend). The window countdown freezes and resumes when `cke_i` returns high.
- R12: A mode write issued while a read window is open is ignored.
- R13: Chip select high, or any other strobe combination, is a no-operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cke_i | input | 1 | Clock enable |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| mr_ni | input | 1 | Mode strobe, active low |
| addr_i | input | 13 | Multiplexed address / mode key |
| wide_i | input | 1 | Width select, 1 = x32, 0 = x16 |
| cas_lat_o | output | 3 | Current CAS latency |
| burst_il_o | output | 1 | Burst order, 1 = interleave |
| burst_len_o | output | 4 | Current burst length |
| row_o | output | 13 | Latched row address |
| rd_req_o | output | 1 | Read request pulse |
| rd_col_o | output | 8 | Column of the read request |
| rd_wide_o | output | 1 | Width of the read request |
| rd_stop_o | output | 1 | Burst termination pulse |
| iclk_en_o | output | 1 | Internal clock enable |
| state_o | output | 2 | 0 idle, 1 read, 2 suspend, 3 power down |
| mrs_err_o | output | 1 | Reserved code pulse |

## Verification
On every cycle, the assertions check that reserved codes leave the fields untouched, that no request leaves during the mode-write lockout or while the internal clock is off, and that a request is always seen inside a read window. They also check that a mode write during a burst changes nothing and that power-down exit lands in idle. Window length, the stop clamp, suspend resumption, row retention through power down and the column width cut can only be shown by the bench's command sequences against its cycle model.

// File: rtl/srom_cmd_pkg.sv
package srom_cmd_pkg;
  typedef enum logic [2:0] {CMD_NOP, CMD_MRS, CMD_ACT, CMD_RD, CMD_STOP} cmd_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_READ = 2'd1, ST_SUSP = 2'd2, ST_PDN = 2'd3} state_e;

  function automatic cmd_e decode_cmd(input logic cs_n, ras_n, cas_n, mr_n);
    cmd_e c;
    c = CMD_NOP;
    if (!cs_n) begin
      if (!ras_n && !cas_n && !mr_n) c = CMD_MRS;
      else if (!ras_n && cas_n)      c = CMD_ACT;
      else if (ras_n && !cas_n && mr_n) c = CMD_RD;
      else if (ras_n && cas_n && !mr_n) c = CMD_STOP;
    end
    return c;
  endfunction
endpackage

// File: rtl/srom_mode_reg.sv
module srom_mode_reg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [5:0] key_i,
  output logic [2:0] cas_lat_o,
  output logic       burst_il_o,
  output logic [3:0] burst_len_o,
  output logic       err_o
);
  logic cl_ok, bl_ok;
  logic [2:0] cl_val;
  logic [3:0] bl_val;

  always_comb begin
    cl_ok  = (key_i[5:3] == 3'b100) || (key_i[5:3] == 3'b101);
    cl_val = (key_i[5:3] == 3'b100) ? 3'd4 : 3'd5;
    bl_ok  = (key_i[1:0] == 2'b01) || (key_i[1:0] == 2'b10);
    bl_val = (key_i[1:0] == 2'b01) ? 4'd4 : 4'd8;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cas_lat_o   <= 3'd5;
      burst_il_o  <= 1'b0;
      burst_len_o <= 4'd4;
      err_o       <= 1'b0;
    end else begin
      err_o <= 1'b0;
      if (wr_i) begin
        burst_il_o <= key_i[2];
        if (cl_ok) cas_lat_o <= cl_val;
        if (bl_ok) burst_len_o <= bl_val;
        err_o <= !(cl_ok && bl_ok);
      end
    end
  end

  // R3
  cl_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && key_i[5:4] != 2'b10) |=> $stable(cas_lat_o));
  // R3
  bl_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (key_i[1:0] == 2'b00 || key_i[1:0] == 2'b11)) |=> $stable(burst_len_o) && err_o);
  // R2
  cl4_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && key_i[5:3] == 3'b100) |=> cas_lat_o == 3'd4);
endmodule

// File: rtl/srom_burst_track.sv
module srom_burst_track
  import srom_cmd_pkg::*;
#(
  parameter int CL_W = 3,
  parameter int BL_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            act_i,
  input  logic            cke_i,
  input  logic            load_i,
  input  logic            stop_i,
  input  logic [CL_W-1:0] cl_i,
  input  logic [BL_W-1:0] bl_i,
  output logic            busy_o,
  output logic [1:0]      state_o
);
  localparam int MAXV  = (2**CL_W - 1) + (2**BL_W - 1);
  localparam int CNT_W = $clog2(MAXV + 1);

  logic [CNT_W-1:0] cnt_q, cnt_n, dec, cl_m1;
  state_e state_q, state_n;

  always_comb begin
    cl_m1 = CNT_W'(cl_i) - CNT_W'(1);
    dec   = (cnt_q != '0) ? cnt_q - CNT_W'(1) : '0;
    cnt_n = cnt_q;
    if (act_i) begin
      if (load_i)                      cnt_n = CNT_W'(cl_i) + CNT_W'(bl_i) - CNT_W'(1);
      else if (stop_i && dec > cl_m1)  cnt_n = cl_m1;
      else                             cnt_n = dec;
    end
    if (cke_i) state_n = (cnt_n != '0) ? ST_READ : ST_IDLE;
    else       state_n = (cnt_n != '0) ? ST_SUSP : ST_PDN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      state_q <= ST_IDLE;
    end else begin
      cnt_q   <= cnt_n;
      state_q <= state_n;
    end
  end

  assign busy_o  = (cnt_q != '0);
  assign state_o = state_q;

  // R11
  frz_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_i |=> $stable(cnt_q));
  // R10
  pdn_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PDN && cke_i) |=> state_q == ST_IDLE);
endmodule

// File: rtl/srom_cmd_ctrl.sv
module srom_cmd_ctrl
  import srom_cmd_pkg::*;
#(
  parameter int ROW_W   = 13,
  parameter int COL_W   = 8,
  parameter int MRS_GAP = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cke_i,
  input  logic             cs_ni,
  input  logic             ras_ni,
  input  logic             cas_ni,
  input  logic             mr_ni,
  input  logic [ROW_W-1:0] addr_i,
  input  logic             wide_i,
  output logic [2:0]       cas_lat_o,
  output logic             burst_il_o,
  output logic [3:0]       burst_len_o,
  output logic [ROW_W-1:0] row_o,
  output logic             rd_req_o,
  output logic [COL_W-1:0] rd_col_o,
  output logic             rd_wide_o,
  output logic             rd_stop_o,
  output logic             iclk_en_o,
  output logic [1:0]       state_o,
  output logic             mrs_err_o
);
  localparam int GAP_W = $clog2(MRS_GAP + 1);

  logic cke_q, act, cmd_ok, busy;
  logic mrs_wr, act_wr, rd_go, stop_go;
  logic [GAP_W-1:0] gap_q;
  cmd_e cmd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cke_q <= 1'b1;
    else         cke_q <= cke_i;
  end

  assign act       = cke_q;
  assign iclk_en_o = cke_q;

  always_comb begin
    cmd     = decode_cmd(cs_ni, ras_ni, cas_ni, mr_ni);
    cmd_ok  = act && (gap_q == '0);
    mrs_wr  = cmd_ok && (cmd == CMD_MRS) && !busy;
    act_wr  = cmd_ok && (cmd == CMD_ACT);
    rd_go   = cmd_ok && (cmd == CMD_RD);
    stop_go = cmd_ok && (cmd == CMD_STOP) && busy;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q     <= '0;
      row_o     <= '0;
      rd_req_o  <= 1'b0;
      rd_col_o  <= '0;
      rd_wide_o <= 1'b0;
      rd_stop_o <= 1'b0;
    end else begin
      if (mrs_wr)                  gap_q <= GAP_W'(MRS_GAP);
      else if (act && gap_q != '0) gap_q <= gap_q - GAP_W'(1);
      if (act_wr) row_o <= addr_i;
      rd_req_o  <= rd_go;
      rd_stop_o <= stop_go;
      if (rd_go) begin
        rd_wide_o <= wide_i;
        rd_col_o  <= wide_i ? {1'b0, addr_i[COL_W-2:0]} : addr_i[COL_W-1:0];
      end
    end
  end

  srom_mode_reg u_mode (
    .clk_i, .rst_ni,
    .wr_i       (mrs_wr),
    .key_i      (addr_i[5:0]),
    .cas_lat_o,
    .burst_il_o,
    .burst_len_o,
    .err_o      (mrs_err_o)
  );

  srom_burst_track #(.CL_W(3), .BL_W(4)) u_track (
    .clk_i, .rst_ni,
    .act_i   (act),
    .cke_i,
    .load_i  (rd_go),
    .stop_i  (stop_go),
    .cl_i    (cas_lat_o),
    .bl_i    (burst_len_o),
    .busy_o  (busy),
    .state_o
  );

  // R4
  gap_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && gap_q != '0) |=> !rd_req_o && !rd_stop_o);
  // R9
  frz_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iclk_en_o |=> $stable(row_o) && !rd_req_o && $stable(cas_lat_o));
  // R7
  req_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> (state_o == ST_READ || state_o == ST_SUSP));
  // R12
  mrs_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && act) |=> $stable(cas_lat_o) && $stable(burst_len_o) && !mrs_err_o);
endmodule

// File: tb/tb_srom_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_srom_cmd_ctrl;
  logic clk = 0, rst_ni = 0, cke = 1, cs_n = 1, ras_n = 1, cas_n = 1, mr_n = 1, wide = 0;
  logic [12:0] addr = '0;
  logic [2:0] cas_lat; logic burst_il; logic [3:0] burst_len; logic [12:0] row;
  logic rd_req, rd_wide, rd_stop, iclk_en, mrs_err; logic [7:0] rd_col; logic [1:0] state;
  int vec = 0, mis = 0, req_cnt = 0;
  bit run = 0, done = 0;

  always #2 clk = ~clk;

  srom_cmd_ctrl dut (
    .clk_i(clk), .rst_ni, .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n), .cas_ni(cas_n),
    .mr_ni(mr_n), .addr_i(addr), .wide_i(wide), .cas_lat_o(cas_lat), .burst_il_o(burst_il),
    .burst_len_o(burst_len), .row_o(row), .rd_req_o(rd_req), .rd_col_o(rd_col),
    .rd_wide_o(rd_wide), .rd_stop_o(rd_stop), .iclk_en_o(iclk_en), .state_o(state),
    .mrs_err_o(mrs_err)
  );

  task automatic chk(input string tag, input string nm, input int act, input int exp);
    vec++;
    if (act != exp) begin
      mis++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, nm, act, exp, $time);
    end
  endtask

  // reference model
  int m_cl, m_il, m_bl, m_row, m_cnt, m_gap, m_cke, m_st, m_req, m_col, m_wide, m_stop, m_err;
  always @(posedge clk) begin
    if (!rst_ni) begin
      m_cl = 5; m_il = 0; m_bl = 4; m_row = 0; m_cnt = 0; m_gap = 0; m_cke = 1; m_st = 0;
      m_req = 0; m_col = 0; m_wide = 0; m_stop = 0; m_err = 0;
    end else begin
      m_req = 0; m_stop = 0; m_err = 0;
      if (m_cke != 0) begin
        int nc;
        nc = (m_cnt > 0) ? m_cnt - 1 : 0;
        if (m_gap > 0) m_gap--;
        else if (!cs_n) begin
          if (!ras_n && !cas_n && !mr_n) begin
            if (m_cnt == 0) begin
              if (addr[5:3] == 3'd4) m_cl = 4; else if (addr[5:3] == 3'd5) m_cl = 5; else m_err = 1;
              if (addr[1:0] == 2'd1) m_bl = 4; else if (addr[1:0] == 2'd2) m_bl = 8; else m_err = 1;
              m_il = addr[2];
              m_gap = 3;
            end
          end else if (!ras_n && cas_n) m_row = addr;
          else if (ras_n && !cas_n && mr_n) begin
            m_req = 1; m_wide = wide;
            m_col = wide ? (addr & 127) : (addr & 255);
            nc = m_cl + m_bl - 1;
          end else if (ras_n && cas_n && !mr_n && m_cnt > 0) begin
            m_stop = 1;
            if (nc > m_cl - 1) nc = m_cl - 1;
          end
        end
        m_cnt = nc;
      end
      m_st = cke ? (m_cnt > 0 ? 1 : 0) : (m_cnt > 0 ? 2 : 3);
      m_cke = cke;
    end
    #1;
    if (rst_ni && run && !done) begin
      if (rd_req) req_cnt++;
      chk("R2 R3 R12", "cas_lat", cas_lat, m_cl);
      chk("R2 R3 R12", "burst_len", burst_len, m_bl);
      chk("R2 R3", "burst_il", burst_il, m_il);
      chk("R3", "mrs_err", mrs_err, m_err);
      chk("R5 R10", "row", row, m_row);
      chk("R4 R6 R13", "rd_req", rd_req, m_req);
      chk("R6", "rd_col", rd_col, m_col);
      chk("R6", "rd_wide", rd_wide, m_wide);
      chk("R8", "rd_stop", rd_stop, m_stop);
      chk("R9", "iclk_en", iclk_en, m_cke);
      chk("R7,R10,R11", "state", state, m_st);
    end
  end

  task automatic cyc(input logic cs, r, c, m, input logic [12:0] a, input logic w, input logic ck);
    @(negedge clk);
    cs_n = cs; ras_n = r; cas_n = c; mr_n = m; addr = a; wide = w; cke = ck;
  endtask
  task automatic nop(input int n, input logic ck = 1);
    repeat (n) cyc(1, 1, 1, 1, 13'h0, 0, ck);
  endtask
  task automatic act_c(input logic [12:0] a);  cyc(0, 0, 1, 1, a, 0, 1); endtask
  task automatic rd_c(input logic [12:0] a, input logic w, input logic ck = 1); cyc(0, 1, 0, 1, a, w, ck); endtask
  task automatic mrs_c(input logic [12:0] a);  cyc(0, 0, 0, 0, a, 0, 1); endtask
  task automatic stop_c();                     cyc(0, 1, 1, 0, 13'h0, 0, 1); endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1; vec++; mis++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vec, mis);
      $finish;
    end
  end

  initial begin
    int base;
    #9;
    // R1 reset state
    chk("R1", "cas_lat", cas_lat, 5);
    chk("R1", "burst_len", burst_len, 4);
    chk("R1", "burst_il", burst_il, 0);
    chk("R1", "state", state, 0);
    chk("R1", "iclk_en", iclk_en, 1);
    chk("R1", "row", row, 0);
    chk("R1", "rd_req", rd_req, 0);
    @(negedge clk); rst_ni = 1; run = 1;
    nop(2);
    act_c(13'h1abc);
    rd_c(13'h0ff, 1); nop(12);
    rd_c(13'h0a5, 0); nop(12);
    // R4 lockout after mode write
    mrs_c(13'h026);
    base = req_cnt;
    rd_c(13'h011, 0); rd_c(13'h012, 0); rd_c(13'h013, 0);
    rd_c(13'h022, 0); nop(3);
    chk("R4", "req_count", req_cnt - base, 1);
    nop(14);
    // R3 reserved codes
    mrs_c(13'h03b); nop(4);
    chk("R3", "cas_lat", cas_lat, 4);
    chk("R3", "burst_len", burst_len, 8);
    // R12 mode write inside a burst
    rd_c(13'h010, 1); mrs_c(13'h02d); nop(15);
    chk("R12", "cas_lat", cas_lat, 4);
    // R8 stop mid burst, then stop while idle
    rd_c(13'h033, 0); nop(2); stop_c(); nop(12);
    stop_c(); nop(3);
    // R13 no-operation encodings
    base = req_cnt;
    cyc(1, 1, 0, 1, 13'h077, 0, 1);
    cyc(0, 0, 0, 1, 13'h077, 0, 1);
    cyc(0, 1, 0, 0, 13'h077, 0, 1);
    nop(3);
    chk("R13", "req_count", req_cnt - base, 0);
    chk("R13", "row", row, 13'h1abc);
    // R10 power down keeps row and ignores commands
    nop(2, 0);
    cyc(0, 0, 1, 1, 13'h0555, 0, 0);
    cyc(0, 1, 0, 1, 13'h0055, 0, 0);
    @(posedge clk); #1 chk("R10", "state", state, 3);
    nop(1, 1); nop(2);
    chk("R10", "row", row, 13'h1abc);
    chk("R10", "state", state, 0);
    // R11 suspend mid burst and on the read cycle
    rd_c(13'h044, 1); nop(2); nop(3, 0); nop(12);
    rd_c(13'h055, 0, 0); nop(2, 0); nop(14);
    // R7 row activate and read during a burst
    rd_c(13'h066, 0); nop(1); act_c(13'h0123); rd_c(13'h067, 1); nop(16);
    chk("R5", "row", row, 13'h0123);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vec, mis);
    $finish;
  end
endmodule